// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block holds the transmit and receive error counters of a CAN node and derives the node's fault-confinement state from them. A protocol engine outside the block reports each outcome as a one-cycle pulse: transmit error, acknowledge error, receive error, successful transmission and successful reception. The block moves the counters by the usual weights and selects one of three states. In Error Active the node takes full part on the bus. In Error Passive it has to be cautious. In Bus Off it must stay off the bus.

Once the node is in Bus Off, the block watches the sampled bus level at each bit-time strobe. The transmit counter is reused as the count of completed runs of eleven recessive bits. When the transmit counter reaches 128 through this recovery, the node rejoins in Error Active with both counters cleared. A freeze input stops all event processing and lets a host load either counter directly. The bench uses this to place the block near any threshold.

The design has three named states: `FC_ACTIVE`, `FC_PASSIVE` and `FC_BUSOFF`. The transitions between them are as follows:
- ACTIVE to PASSIVE (either counter reaches 128).
- PASSIVE to ACTIVE (both counters at 127 or less).
- ACTIVE or PASSIVE to BUSOFF (a transmit-counter step would pass 255).
- BUSOFF to ACTIVE (recovery completes).

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters are 0, the state code is 00 (Error Active) and the interrupt output is low.
- R2: Outside Bus Off and freeze, a transmit error adds 8 to the transmit counter. An acknowledge error also adds 8, but only in Error Active. A successful transmission subtracts 1, with the count floored at 0. An error pulse wins over a success pulse in the same cycle.
- R3: Outside Bus Off and freeze, a receive error adds 1 to the receive counter while the counter is below 128. At 128 or above, receive errors leave it unchanged. A successful reception with the counter below 128 subtracts 1, with the count floored at 0.
- R4: A successful reception with the receive counter at 128 or above loads the counter with 127.
- R5: The state code is 01 (Error Passive) on the cycle the counter update leaves either counter at 128 or more.
- R6: From Error Passive, the state code returns to 00 on the cycle the update leaves both counters at 127 or less.
- R7: In Error Passive an acknowledge error leaves the transmit counter unchanged.
- R8: When a transmit-counter step would exceed 255, the state code becomes 10 (Bus Off) and the transmit counter becomes 0. The interrupt output is high for exactly that one cycle.
- R9: In Bus Off, error and success pulses change neither counter.
- R10: In Bus Off, on each strobe with the bus bit high (recessive), a run count advances. Completing 11 strobes in a row adds 1 to the transmit counter. A strobe with the bus bit low (dominant) restarts the run and leaves the transmit counter unchanged.
- R11: When the recovery increment would bring the transmit counter to 128, the state code becomes 00 and both counters become 0.
- R12: A counter write loads the data only while freeze is high. While freeze is high, event pulses are ignored. Outside Bus Off, the state code follows the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err | input | 1 | Transmit error pulse |
| ack_err | input | 1 | Acknowledge error pulse |
| rx_err | input | 1 | Receive error pulse |
| tx_ok | input | 1 | Successful transmission pulse |
| rx_ok | input | 1 | Successful reception pulse |
| bit_stb | input | 1 | One pulse per bus bit time |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| frz | input | 1 | Freeze: block events, enable writes |
| wr_tec | input | 1 | Load transmit counter (freeze only) |
| wr_rec | input | 1 | Load receive counter (freeze only) |
| wr_data | input | 8 | Value to load |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| state | output | 2 | 00 active, 01 passive, 10 bus off |
| busoff_irq | output | 1 | One-cycle pulse on Bus Off entry |

## Verification
The hardest situation to reach from the ports is the end of Bus Off recovery. It needs an entry into Bus Off followed by 128 completed runs of eleven recessive strobes, and the last run must land exactly on the transmit count of 127. The stimulus first uses freeze writes to preload the transmit counter at 250, so that a single transmit error overflows it. It then interrupts a ten-bit recessive run with one dominant bit and finally streams an unbroken recessive sequence. The counter and state are checked just before and just after the final increment.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_e;
endpackage

// File: rtl/can_fc_tec.sv
module can_fc_tec
    import can_fc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int STEP  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frz,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  fc_state_e        st,
    input  logic             tx_err,
    input  logic             ack_err,
    input  logic             tx_ok,
    input  logic             rcv_inc,
    input  logic             rcv_clr,
    output logic [CNT_W-1:0] tec_q,
    output logic [CNT_W-1:0] tec_d,
    output logic             ovf
);
    localparam logic [CNT_W:0]   STEP_W = (CNT_W+1)'(STEP);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic           step_hit;
    logic [CNT_W:0] sum;

    always_comb begin
        step_hit = !frz && (st != FC_BUSOFF)
                   && (tx_err || (ack_err && st == FC_ACTIVE));
        sum      = {1'b0, tec_q} + STEP_W;
        ovf      = step_hit && sum[CNT_W];
    end

    always_comb begin
        tec_d = tec_q;
        if (frz) begin
            if (wr_en) tec_d = wr_data;
        end else if (st == FC_BUSOFF) begin
            if (rcv_clr)      tec_d = '0;
            else if (rcv_inc) tec_d = tec_q + ONE;
        end else if (step_hit) begin
            tec_d = ovf ? '0 : sum[CNT_W-1:0];
        end else if (tx_ok && tec_q != '0) begin
            tec_d = tec_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tec_q <= '0;
        else        tec_q <= tec_d;
    end

    // R7
    ack_passive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FC_PASSIVE && ack_err && !tx_err && !tx_ok && !frz)
        |=> tec_q == $past(tec_q));

    // R12
    frz_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frz && !wr_en) |=> tec_q == $past(tec_q));
endmodule

// File: rtl/can_fc_rec.sv
module can_fc_rec #(
    parameter int CNT_W  = 8,
    parameter int RELOAD = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frz,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             busoff,
    input  logic             rx_err,
    input  logic             rx_ok,
    input  logic             rcv_clr,
    output logic [CNT_W-1:0] rec_q,
    output logic [CNT_W-1:0] rec_d
);
    localparam logic [CNT_W-1:0] LIM   = CNT_W'(1 << (CNT_W - 1));
    localparam logic [CNT_W-1:0] RLD   = CNT_W'(RELOAD);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    always_comb begin
        rec_d = rec_q;
        if (frz) begin
            if (wr_en) rec_d = wr_data;
        end else if (busoff) begin
            if (rcv_clr) rec_d = '0;
        end else if (rx_err) begin
            if (rec_q < LIM) rec_d = rec_q + ONE;
        end else if (rx_ok) begin
            if (rec_q >= LIM)       rec_d = RLD;
            else if (rec_q != '0)   rec_d = rec_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    // R3
    rec_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz && !busoff && rx_err && rec_q >= LIM) |=> rec_q == $past(rec_q));

    // R9
    busoff_rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff && !frz && !rcv_clr) |=> rec_q == $past(rec_q));
endmodule

// File: rtl/can_fc_run.sv
module can_fc_run #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busoff,
    input  logic frz,
    input  logic bit_stb,
    input  logic bus_bit,
    output logic wrap
);
    localparam int             RW       = $clog2(RUN_LEN);
    localparam logic [RW-1:0]  RUN_LAST = RW'(RUN_LEN - 1);
    localparam logic [RW-1:0]  ONE      = RW'(1);

    logic [RW-1:0] run_q;
    logic          adv;

    always_comb begin
        adv  = busoff && !frz && bit_stb;
        wrap = adv && bus_bit && (run_q == RUN_LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !busoff) run_q <= '0;
        else if (adv) begin
            if (!bus_bit || wrap) run_q <= '0;
            else                  run_q <= run_q + ONE;
        end
    end

    // R10
    run_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_LAST);
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
    import can_fc_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int TX_STEP = 8,
    parameter int RUN_LEN = 11,
    parameter int RELOAD  = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err,
    input  logic             ack_err,
    input  logic             rx_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             bit_stb,
    input  logic             bus_bit,
    input  logic             frz,
    input  logic             wr_tec,
    input  logic             wr_rec,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] tec,
    output logic [CNT_W-1:0] rec,
    output logic [1:0]       state,
    output logic             busoff_irq
);
    localparam logic [CNT_W-1:0] LIM      = CNT_W'(1 << (CNT_W - 1));
    localparam logic [CNT_W-1:0] REC_LAST = LIM - CNT_W'(1);

    fc_state_e        state_q, state_d;
    logic [CNT_W-1:0] tec_d, rec_d;
    logic             ovf, run_wrap, recover, in_busoff;

    assign in_busoff = (state_q == FC_BUSOFF);
    assign recover   = in_busoff && run_wrap && (tec == REC_LAST);

    can_fc_run #(.RUN_LEN(RUN_LEN)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .busoff  (in_busoff),
        .frz     (frz),
        .bit_stb (bit_stb),
        .bus_bit (bus_bit),
        .wrap    (run_wrap)
    );

    can_fc_tec #(.CNT_W(CNT_W), .STEP(TX_STEP)) u_tec (
        .clk     (clk),
        .rst_n   (rst_n),
        .frz     (frz),
        .wr_en   (wr_tec),
        .wr_data (wr_data),
        .st      (state_q),
        .tx_err  (tx_err),
        .ack_err (ack_err),
        .tx_ok   (tx_ok),
        .rcv_inc (run_wrap),
        .rcv_clr (recover),
        .tec_q   (tec),
        .tec_d   (tec_d),
        .ovf     (ovf)
    );

    can_fc_rec #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .frz     (frz),
        .wr_en   (wr_rec),
        .wr_data (wr_data),
        .busoff  (in_busoff),
        .rx_err  (rx_err),
        .rx_ok   (rx_ok),
        .rcv_clr (recover),
        .rec_q   (rec),
        .rec_d   (rec_d)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE, FC_PASSIVE: begin
                if (ovf)                              state_d = FC_BUSOFF;
                else if (tec_d >= LIM || rec_d >= LIM) state_d = FC_PASSIVE;
                else                                  state_d = FC_ACTIVE;
            end
            FC_BUSOFF: begin
                if (recover) state_d = FC_ACTIVE;
            end
            default: state_d = FC_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FC_ACTIVE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) busoff_irq <= 1'b0;
        else        busoff_irq <= ovf;
    end

    assign state = state_q;

    // R8
    irq_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_irq |-> (state == 2'b10 && tec == '0));

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_irq |=> !busoff_irq);

    // R5
    passive_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'b10) |-> ((state == 2'b01) == (tec >= LIM || rec >= LIM)));

    // R10
    dominant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_busoff && !frz && bit_stb && !bus_bit) |=> $stable(tec));

    // R11
    recover_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> (state == 2'b00 && tec == '0 && rec == '0));
endmodule

// File: tb/sim_can_fault_conf.sv
module sim_can_fault_conf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err = 0, ack_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0;
    logic       bit_stb = 0, bus_bit = 1, frz = 0, wr_tec = 0, wr_rec = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] tec, rec;
    logic [1:0] state;
    logic       busoff_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    can_fault_conf u0 (
        .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .ack_err(ack_err),
        .rx_err(rx_err), .tx_ok(tx_ok), .rx_ok(rx_ok), .bit_stb(bit_stb),
        .bus_bit(bus_bit), .frz(frz), .wr_tec(wr_tec), .wr_rec(wr_rec),
        .wr_data(wr_data), .tec(tec), .rec(rec), .state(state),
        .busoff_irq(busoff_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_all(input string req, input int t, input int r,
                              input int s, input int irq);
        chk({req, " tec"}, int'(tec), t);
        chk({req, " rec"}, int'(rec), r);
        chk({req, " state"}, int'(state), s);
        chk({req, " irq"}, int'(busoff_irq), irq);
    endtask

    // one cycle of event pulses; called and returns at a falling edge
    task automatic ev(input logic te, input logic ae, input logic re,
                      input logic to, input logic ro);
        tx_err = te; ack_err = ae; rx_err = re; tx_ok = to; rx_ok = ro;
        @(negedge clk);
        tx_err = 0; ack_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0;
    endtask

    task automatic load(input logic f, input logic wt, input logic wr,
                        input logic [7:0] d);
        frz = f; wr_tec = wt; wr_rec = wr; wr_data = d;
        @(negedge clk);
        frz = 0; wr_tec = 0; wr_rec = 0; wr_data = '0;
    endtask

    task automatic bits(input int n, input logic lvl);
        bit_stb = 1; bus_bit = lvl;
        for (int i = 0; i < n; i++) @(negedge clk);
        bit_stb = 0; bus_bit = 1;
    endtask

    task automatic t_reset;
        expect_all("R1", 0, 0, 0, 0);
    endtask

    task automatic t_tx;
        ev(1, 0, 0, 0, 0); chk("R2 tx_err +8", int'(tec), 8);
        ev(1, 0, 0, 1, 0); chk("R2 error beats success", int'(tec), 16);
        ev(0, 1, 0, 0, 0); chk("R2 ack active +8", int'(tec), 24);
        for (int i = 0; i < 25; i++) ev(0, 0, 0, 1, 0);
        chk("R2 floor at 0", int'(tec), 0);
    endtask

    task automatic t_rx;
        for (int i = 0; i < 3; i++) ev(0, 0, 1, 0, 0);
        chk("R3 rx_err +1", int'(rec), 3);
        for (int i = 0; i < 4; i++) ev(0, 0, 0, 0, 1);
        chk("R3 rx floor", int'(rec), 0);
    endtask

    task automatic t_passive;
        load(1, 1, 0, 8'd120);
        expect_all("R12 frozen write", 120, 0, 0, 0);
        frz = 1; ev(1, 0, 1, 0, 0); frz = 0;
        expect_all("R12 frozen events", 120, 0, 0, 0);
        load(0, 1, 0, 8'd5);
        chk("R12 write without freeze", int'(tec), 120);
        ev(1, 0, 0, 0, 0);
        expect_all("R5 tec 128", 128, 0, 1, 0);
        ev(0, 1, 0, 0, 0);
        expect_all("R7 ack passive", 128, 0, 1, 0);
        ev(0, 0, 0, 1, 0);
        expect_all("R6 back active", 127, 0, 0, 0);
    endtask

    task automatic t_rec;
        load(1, 0, 1, 8'd127);
        ev(0, 0, 1, 0, 0);
        expect_all("R5 rec 128", 127, 128, 1, 0);
        ev(0, 0, 1, 0, 0);
        chk("R3 rec saturates", int'(rec), 128);
        ev(0, 0, 0, 0, 1);
        expect_all("R4 reload 127", 127, 127, 0, 0);
    endtask

    task automatic t_busoff;
        load(1, 0, 1, 8'd5);
        load(1, 1, 0, 8'd250);
        chk("R5 written state", int'(state), 1);
        ev(1, 0, 0, 0, 0);
        expect_all("R8 bus off entry", 0, 5, 2, 1);
        @(negedge clk);
        chk("R8 irq one cycle", int'(busoff_irq), 0);
        ev(1, 1, 1, 1, 1);
        expect_all("R9 events ignored", 0, 5, 2, 0);
    endtask

    task automatic t_recover;
        bits(10, 1); bits(1, 0);
        chk("R10 dominant restart", int'(tec), 0);
        bits(10, 1);
        chk("R10 ten recessive", int'(tec), 0);
        bits(1, 1);
        chk("R10 eleventh recessive", int'(tec), 1);
        bits(11 * 126, 1);
        chk("R10 127 runs", int'(tec), 127);
        bits(10, 1);
        expect_all("R11 before last", 127, 5, 2, 0);
        bits(1, 1);
        expect_all("R11 recovered", 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx();
        t_rx();
        t_passive();
        t_rec();
        t_busoff();
        t_recover();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule